// File: doc/BRIEF.md
# Stream-to-Link Clock Ratio Meter

This block measures how fast a pixel stream clock runs compared with a link symbol clock. It publishes the result as a fraction: a measured numerator `ratio_m` over a fixed denominator `ratio_n`. A free-running counter in the link domain marks out measurement windows of exactly `ratio_n` link cycles. A second counter in the stream domain counts stream cycles. When a window closes, the stream count is captured, the stream counter restarts from zero, and the captured value is returned to the link domain through a toggle request/acknowledge handshake. There it becomes the new numerator.

A receiver that has the link clock can rebuild the stream clock by scaling it by `ratio_m / ratio_n`. If the two clocks hold a steady relationship, every window gives the same numerator. Slow drift between the clocks appears as small steps in that value from one window to the next.

The first window after reset, or after `meas_en` rises, may have started part-way through a stream count, so its result is thrown away. The numerator reads zero and `m_valid` stays low until one complete window has been measured.

Top module: `clk_ratio_meter`

## Requirements
- R1: `ratio_n` always equals 2**WIN_LOG2 link cycles. This is 32768 with the default parameters.
- R2: A measurement window is exactly 2**WIN_LOG2 consecutive link cycles with `meas_en` high. The published `ratio_m` equals the number of stream clock rising edges that fall within one such window.
- R3: If the stream count exceeds the width of `ratio_m`, the published value is all ones (2**M_W-1) rather than a wrapped value.
- R4: `ratio_m` changes only in a cycle where `m_upd` is high, or when it is cleared by `meas_en` being low or by reset.
- R5: `m_upd` is a single-cycle pulse. Exactly one pulse is issued for each completed window after the first. It arrives within 3 stream cycles plus 4 link cycles of the window end, and only while `meas_en` is high.
- R6: The window that ends first after reset or enable produces no update. Until the second window ends, `ratio_m` is 0 and `m_valid` is 0.
- R7: While `lnk_rst` is high or `meas_en` is low, the next link edge forces `ratio_m` to 0, `m_valid` to 0 and `m_upd` to 0, and restarts the window count. A capture that is in flight when `meas_en` falls is never published.
- R8: With a constant clock ratio, successive windows publish the same `ratio_m`.
- R9: `m_valid` rises together with the first `m_upd` pulse. It stays high until `meas_en` falls or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lnk_clk | input | 1 | Link symbol clock |
| lnk_rst | input | 1 | Synchronous active-high reset, link domain |
| str_clk | input | 1 | Pixel stream clock, asynchronous to the link clock |
| str_rst | input | 1 | Synchronous active-high reset, stream domain |
| meas_en | input | 1 | Measurement enable, link domain |
| ratio_m | output | M_W | Measured numerator: stream cycles per window |
| ratio_n | output | WIN_LOG2+1 | Fixed denominator: link cycles per window |
| m_upd | output | 1 | One-cycle pulse when a new numerator is latched |
| m_valid | output | 1 | High once a full window has been published |

## Verification
The hardest case to reach is an acknowledge that returns after `meas_en` has already fallen. It can only arise when the enable drops in the few cycles between a window end and the return of the handshake. The stimulus reaches it by slowing the stream clock to widen that gap. It then drops the enable two cycles after the second window end and confirms that nothing is published while the enable stays low or after re-enable. Exact expected numerators are possible because the stimulus only uses stream periods that divide the window length evenly. Each period change is made while the block is disabled.

// File: rtl/crm_pkg.sv
package crm_pkg;
  // Link-side progress through the measurement sequence
  typedef enum logic [1:0] {
    MEAS_IDLE  = 2'd0,  // no window has ended since enable
    MEAS_PRIME = 2'd1,  // first (partial) window ended; its result is discarded
    MEAS_ARMED = 2'd2   // full windows in progress; results are published
  } meas_state_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/crm_toggle_sync.sv
module crm_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic pulse
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], tgl_in};
      last  <= chain[STAGES-1];
    end
  end

  assign pulse = chain[STAGES-1] ^ last;
endmodule

// File: rtl/crm_win_timer.sv
module crm_win_timer #(
  parameter int WIN_LOG2 = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic win_end,
  output logic req_tgl
);
  logic [WIN_LOG2-1:0] win_cnt;

  assign win_end = en && (win_cnt == {WIN_LOG2{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
      req_tgl <= 1'b0;
    end else if (!en) begin
      win_cnt <= '0;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      if (win_end) req_tgl <= ~req_tgl;
    end
  end
endmodule

// File: rtl/crm_str_counter.sv
module crm_str_counter #(
  parameter int M_W    = 24,
  parameter int STAGES = 2
) (
  input  logic           str_clk,
  input  logic           str_rst,
  input  logic           req_tgl,
  output logic [M_W-1:0] snap,
  output logic           ack_tgl
);
  logic [M_W-1:0] cnt;
  logic [M_W-1:0] cnt_next;
  logic           req_pulse;

  crm_toggle_sync #(.STAGES(STAGES)) u_req_sync (
    .clk    (str_clk),
    .rst    (str_rst),
    .tgl_in (req_tgl),
    .pulse  (req_pulse)
  );

  // saturating increment: counts this edge
  assign cnt_next = (cnt == {M_W{1'b1}}) ? cnt : cnt + 1'b1;

  always_ff @(posedge str_clk) begin
    if (str_rst) begin
      cnt     <= '0;
      snap    <= '0;
      ack_tgl <= 1'b0;
    end else if (req_pulse) begin
      snap    <= cnt_next;
      cnt     <= '0;
      ack_tgl <= ~ack_tgl;
    end else begin
      cnt <= cnt_next;
    end
  end
endmodule

// File: rtl/clk_ratio_meter.sv
module clk_ratio_meter #(
  parameter int WIN_LOG2 = 15,
  parameter int M_W      = 24
) (
  input  logic                lnk_clk,
  input  logic                lnk_rst,
  input  logic                str_clk,
  input  logic                str_rst,
  input  logic                meas_en,
  output logic [M_W-1:0]      ratio_m,
  output logic [WIN_LOG2:0]   ratio_n,
  output logic                m_upd,
  output logic                m_valid
);
  import crm_pkg::*;

  localparam logic [WIN_LOG2:0] N_VAL = {1'b1, {WIN_LOG2{1'b0}}};

  logic           win_end;
  logic           req_tgl;
  logic           ack_tgl;
  logic           ack_pulse;
  logic [M_W-1:0] snap;
  meas_state_e    state;

  crm_win_timer #(.WIN_LOG2(WIN_LOG2)) u_timer (
    .clk     (lnk_clk),
    .rst     (lnk_rst),
    .en      (meas_en),
    .win_end (win_end),
    .req_tgl (req_tgl)
  );

  crm_str_counter #(.M_W(M_W), .STAGES(SYNC_STAGES)) u_str (
    .str_clk (str_clk),
    .str_rst (str_rst),
    .req_tgl (req_tgl),
    .snap    (snap),
    .ack_tgl (ack_tgl)
  );

  crm_toggle_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk    (lnk_clk),
    .rst    (lnk_rst),
    .tgl_in (ack_tgl),
    .pulse  (ack_pulse)
  );

  assign ratio_n = N_VAL;

  always_ff @(posedge lnk_clk) begin
    if (lnk_rst || !meas_en) begin
      state   <= MEAS_IDLE;
      ratio_m <= '0;
      m_upd   <= 1'b0;
      m_valid <= 1'b0;
    end else begin
      m_upd <= 1'b0;
      if (win_end) begin
        case (state)
          MEAS_IDLE: state <= MEAS_PRIME;
          default:   state <= MEAS_ARMED;
        endcase
      end
      // snap is stable here: it changed with ack_tgl, two or more link edges ago
      if (ack_pulse && state == MEAS_ARMED) begin
        ratio_m <= snap;
        m_upd   <= 1'b1;
        m_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/crm_checker.sv
module crm_checker #(
  parameter int M_W = 24
) (
  input logic           lnk_clk,
  input logic           lnk_rst,
  input logic           meas_en,
  input logic [M_W-1:0] ratio_m,
  input logic           m_upd,
  input logic           m_valid
);
  p_hold_r4: assert property (@(posedge lnk_clk) disable iff (lnk_rst)
    ($past(meas_en) && !m_upd) |-> $stable(ratio_m));

  p_pulse_r5: assert property (@(posedge lnk_clk) disable iff (lnk_rst)
    m_upd |=> !m_upd);

  p_upd_en_r5: assert property (@(posedge lnk_clk) disable iff (lnk_rst)
    m_upd |-> $past(meas_en));

  p_zero_invalid_r6: assert property (@(posedge lnk_clk) disable iff (lnk_rst)
    !m_valid |-> (ratio_m == '0));

  p_off_clear_r7: assert property (@(posedge lnk_clk) disable iff (lnk_rst)
    !meas_en |=> (!m_valid && !m_upd && ratio_m == '0));

  p_valid_r9: assert property (@(posedge lnk_clk) disable iff (lnk_rst)
    m_upd |-> m_valid);
endmodule

bind clk_ratio_meter crm_checker #(.M_W(M_W)) u_chk (
  .lnk_clk (lnk_clk),
  .lnk_rst (lnk_rst),
  .meas_en (meas_en),
  .ratio_m (ratio_m),
  .m_upd   (m_upd),
  .m_valid (m_valid)
);

// File: tb/clk_ratio_meter_tb.sv
`timescale 1ns/1ps
module clk_ratio_meter_tb;
  localparam int  WL = 10;
  localparam int  MW = 12;
  localparam int  W  = 1 << WL;
  localparam int  G  = 24;          // update latency allowance in link cycles
  localparam real LP = 4.0;         // 250 MHz link clock

  logic lnk_clk = 1'b0, str_clk = 1'b0;
  logic lnk_rst = 1'b1, str_rst = 1'b1, meas_en = 1'b0;
  real  str_half = 4.0;

  logic [MW-1:0] ratio_m;
  logic [WL:0]   ratio_n;
  logic          m_upd, m_valid;

  clk_ratio_meter #(.WIN_LOG2(WL), .M_W(MW)) u_dut (
    .lnk_clk (lnk_clk), .lnk_rst (lnk_rst),
    .str_clk (str_clk), .str_rst (str_rst),
    .meas_en (meas_en),
    .ratio_m (ratio_m), .ratio_n (ratio_n),
    .m_upd   (m_upd),   .m_valid (m_valid)
  );

  always #(LP/2) lnk_clk = ~lnk_clk;
  initial begin
    #0.3;
    forever #(str_half) str_clk = ~str_clk;
  end

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // ---- behavioural reference model, compared every link cycle ----
  logic en_e = 1'b0, rst_e = 1'b1;
  always @(posedge lnk_clk) begin
    en_e  <= meas_en;
    rst_e <= lnk_rst;
  end

  int ecnt = 0, grace = 0, seen = 0, exp_m = 0, next_m = 0;
  bit exp_v = 0;

  always @(negedge lnk_clk) if (!done) begin
    chk(ratio_n == W, "R1", ratio_n, W);
    if (rst_e || !en_e) begin
      ecnt = 0; grace = 0; exp_m = 0; exp_v = 0;
      // R7: cleared state
      chk(ratio_m == 0 && !m_valid && !m_upd, "R7", ratio_m, 0);
    end else begin
      ecnt++;
      if (ecnt % W == 0 && ecnt / W >= 2) begin
        grace = G;
        seen  = 0;
      end
      if (grace > 0) begin
        if (m_upd) begin
          seen++;
          exp_m = next_m;
          exp_v = 1;
          chk(ratio_m == next_m && m_valid, "R2", ratio_m, next_m);  // and R9
        end else begin
          chk(ratio_m == exp_m && m_valid == exp_v, "R4", ratio_m, exp_m);
        end
        grace--;
        if (grace == 0) chk(seen == 1, "R5", seen, 1);
      end else begin
        // R6: no update outside the window-end allowance (first window discarded)
        chk(!m_upd && ratio_m == exp_m && m_valid == exp_v, "R6", ratio_m, exp_m);
      end
    end
  end

  function automatic int expect_m(input real half);
    int ideal;
    ideal = int'(W * LP / (2.0 * half));
    return (ideal > (1 << MW) - 1) ? (1 << MW) - 1 : ideal;
  endfunction

  task automatic run_meas(input real half, input int windows, input string req);
    str_half = half;
    next_m   = expect_m(half);
    repeat (10) @(posedge lnk_clk);
    #1 meas_en = 1'b1;
    repeat (W) @(posedge lnk_clk);
    #1 chk(!m_valid && ratio_m == 0, "R6", ratio_m, 0);
    repeat ((windows - 1) * W + G + 2) @(posedge lnk_clk);
    #1 chk(ratio_m == next_m && m_valid, req, ratio_m, next_m);
    repeat (W) @(posedge lnk_clk);
    #1 chk(ratio_m == next_m && m_valid, "R8", ratio_m, next_m);  // repeat window, same value
    chk(m_valid, "R9", m_valid, 1);
    repeat (100) @(posedge lnk_clk);
    #1 meas_en = 1'b0;                                             // mid-window drop
    repeat (40) @(posedge lnk_clk);
  endtask

  initial begin
    repeat (10) @(posedge lnk_clk);
    #1;
    chk(ratio_m == 0 && !m_valid && !m_upd, "R7", ratio_m, 0);     // reset state
    lnk_rst = 1'b0;
    str_rst = 1'b0;
    repeat (5) @(posedge lnk_clk);

    run_meas(4.0, 2, "R2");   // period 8 ns  -> 512
    run_meas(1.0, 2, "R2");   // period 2 ns  -> 2048
    run_meas(0.5, 2, "R3");   // period 1 ns  -> 4096 saturates to 4095
    run_meas(8.0, 2, "R2");   // period 16 ns -> 256

    // in-flight capture cancelled by enable drop (R7)
    str_half = 8.0;
    next_m   = expect_m(8.0);
    repeat (10) @(posedge lnk_clk);
    #1 meas_en = 1'b1;
    repeat (2 * W + 2) @(posedge lnk_clk);
    #1 meas_en = 1'b0;
    repeat (60) @(posedge lnk_clk);
    #1 chk(ratio_m == 0 && !m_valid, "R7", ratio_m, 0);
    run_meas(8.0, 2, "R2");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(190000 * LP);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule